// File: doc/BRIEF.md
# Minute-Granularity Key-Locked Watchdog

This block is a software watchdog that counts down in whole minutes. Software loads a byte-wide minute count while the watchdog is stopped. It then writes a magic key byte to a lock register to start the watchdog. A second key byte stops it. Any other value written to the lock register does nothing.

While the watchdog runs, a prescaler turns qualifying ticks into minute strobes, and each strobe takes one minute off the count. When the count reaches zero, the block emits a single-cycle timeout pulse, latches a sticky status flag and stops counting. The count cannot be reloaded while the watchdog runs. To feed it, software stops it, reloads the count and starts it again. A read of the timer register always returns the minutes that remain.

Top module: `minute_watchdog`

## Requirements
- R1: After reset the watchdog is stopped, the status flag is clear, the timeout output is low and the timer reads RESET_MINUTES (default 1).
- R2: Register offsets are: 0 = lock (write-only, reads 0x00), 1 = run state (reads 0x01 when running, else 0x00), 2 = status (reads 0x01 when a timeout has occurred, else 0x00), 3 = timer. Writing 0x55 to offset 0 starts the watchdog and writing 0xAA to offset 0 stops it.
- R3: A write to offset 0 of any value other than 0x55 or 0xAA changes neither the run state nor the count.
- R4: While stopped, a write to offset 3 stores the byte, and a read of offset 3 returns it.
- R5: While running, writes to offset 3 are refused and the count is unchanged.
- R6: While running with a nonzero count, the count drops by one every TICKS_PER_MIN qualifying ticks. The first drop comes a full TICKS_PER_MIN ticks after the start key is written, because starting restarts the prescaler.
- R7: With external ticks selected, a clock cycle is a qualifying tick only when tick_in is high. While tick_in is low the count does not advance.
- R8: When the count steps from 1 to 0, timeout_pulse is high for exactly one cycle and the status flag sets. The count then stays at 0 and no further pulse follows.
- R9: Starting the watchdog with a count of 0 marks it as running but never produces a pulse or a status flag.
- R10: The stop key freezes the count and the prescaler phase and clears the status flag. A later start key restarts the prescaler from zero.
- R11: Writes to offsets 1 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | Tick qualifier for the prescaler when external ticks are selected |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| timeout_pulse | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The results are due at the following times:
- A register write takes effect at the clock edge that samples it.
- Reads are combinational, so they are checked a moment after the address is driven, half a cycle from any edge.
- With tick_in held high, the count drops at the TICKS_PER_MIN-th edge after the start key edge, and the pulse appears at that same edge for the final minute.

The bench tracks every edge that passes since the start key was written. It reads the timer one cycle before each drop and again at the cycle of the drop, so that an early or a late prescaler shows up as a mismatch. A monitor counts every pulse seen, which shows that no extra pulse occurs after zero.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] KEY_START = 8'h55;
    localparam logic [DATA_W-1:0] KEY_STOP  = 8'hAA;

    typedef enum logic [1:0] {
        SEL_LOCK = 2'd0,
        SEL_RUN  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_TMR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              start;
        logic              stop;
        logic              load;
        logic [DATA_W-1:0] load_val;
    } wdt_cmd_t;

    typedef struct packed {
        logic              running;
        logic [DATA_W-1:0] minutes;
        logic              status;
        logic              pulse;
    } wdt_state_t;

endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode
    import wdt_pkg::*;
(
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              running,
    output wdt_cmd_t          cmd
);
    logic lock_wr;
    logic tmr_wr;

    always_comb begin
        lock_wr      = reg_we && (reg_sel_e'(reg_addr) == SEL_LOCK);
        tmr_wr       = reg_we && (reg_sel_e'(reg_addr) == SEL_TMR);
        cmd.start    = lock_wr && (reg_wdata == KEY_START);
        cmd.stop     = lock_wr && (reg_wdata == KEY_STOP);
        // reloads are refused while the watchdog is running
        cmd.load     = tmr_wr && !running;
        cmd.load_val = reg_wdata;
    end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int TICKS_PER_MIN = 60,
    parameter bit USE_EXT_TICK  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick_in,
    output logic minute_stb
);
    localparam int CNT_W = (TICKS_PER_MIN > 2) ? $clog2(TICKS_PER_MIN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_MIN - 1);

    logic             qual;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    generate
        if (USE_EXT_TICK) begin : g_ext
            assign qual = tick_in;
        end else begin : g_clk
            assign qual = 1'b1;
        end
    endgenerate

    always_comb begin
        minute_stb = run && qual && (cnt_q == LAST);
        cnt_d      = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run && qual) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int RESET_MINUTES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  wdt_cmd_t   cmd,
    input  logic       minute_stb,
    output wdt_state_t st,
    output logic       run
);
    wdt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (cmd.load) st_d.minutes = cmd.load_val;
        if (minute_stb && st_q.minutes != '0) begin
            st_d.minutes = st_q.minutes - 1'b1;
            if (st_q.minutes == DATA_W'(1)) begin
                st_d.pulse  = 1'b1;
                st_d.status = 1'b1;
            end
        end
        if (cmd.stop) begin
            st_d.running = 1'b0;
            if (!st_d.pulse) st_d.status = 1'b0;
        end else if (cmd.start) begin
            st_d.running = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.running <= 1'b0;
            st_q.minutes <= DATA_W'(RESET_MINUTES);
            st_q.status  <= 1'b0;
            st_q.pulse   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st  = st_q;
    assign run = st_q.running && (st_q.minutes != '0);

endmodule

// File: rtl/minute_watchdog.sv
module minute_watchdog
    import wdt_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60,
    parameter bit USE_EXT_TICK  = 1'b1,
    parameter int RESET_MINUTES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              timeout_pulse
);
    wdt_cmd_t   cmd;
    wdt_state_t st;
    logic       run;
    logic       minute_stb;

    wdt_key_decode u_dec (
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .running   (st.running),
        .cmd       (cmd)
    );

    wdt_prescaler #(
        .TICKS_PER_MIN (TICKS_PER_MIN),
        .USE_EXT_TICK  (USE_EXT_TICK)
    ) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .restart    (cmd.start),
        .tick_in    (tick_in),
        .minute_stb (minute_stb)
    );

    wdt_countdown #(
        .RESET_MINUTES (RESET_MINUTES)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .minute_stb (minute_stb),
        .st         (st),
        .run        (run)
    );

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            SEL_LOCK: reg_rdata = '0;
            SEL_RUN:  reg_rdata = {{(DATA_W-1){1'b0}}, st.running};
            SEL_STAT: reg_rdata = {{(DATA_W-1){1'b0}}, st.status};
            default:  reg_rdata = st.minutes;
        endcase
    end

    assign timeout_pulse = st.pulse;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       timeout_pulse,
    input logic       running,
    input logic [7:0] minutes,
    input logic       status,
    input logic       stb
);
    logic stop_wr;
    logic start_wr;
    assign stop_wr  = reg_we && reg_addr == 2'd0 && reg_wdata == 8'hAA;
    assign start_wr = reg_we && reg_addr == 2'd0 && reg_wdata == 8'h55;

    // R8: the pulse lasts one cycle
    a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    // R8: the pulse comes with the status flag
    a_r8_pulse_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> status);

    // R8 R10: status is sticky until the stop key
    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !stop_wr) |=> status);

    // R5: while running, only a minute strobe moves the count
    a_r5_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !stb) |=> $stable(minutes));

    // R6: each strobe takes exactly one minute off
    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (minutes == $past(minutes) - 8'd1));

    // R9: a zero count never strobes
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (minutes == 8'd0) |-> !stb);

    // R2: the start key starts the watchdog
    a_r2_start_key: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> running);

endmodule

bind minute_watchdog wdt_checker u_wdt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .timeout_pulse (timeout_pulse),
    .running       (st.running),
    .minutes       (st.minutes),
    .status        (st.status),
    .stb           (minute_stb)
);

// File: tb/test_minute_watchdog.sv
module test_minute_watchdog;
    localparam int TPM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       timeout_pulse;

    int errors = 0;
    int checks = 0;
    int pulses = 0;

    always #2.5 clk = ~clk;

    minute_watchdog #(.TICKS_PER_MIN(TPM), .USE_EXT_TICK(1'b1), .RESET_MINUTES(1)) i_minute_watchdog (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .timeout_pulse(timeout_pulse)
    );

    always @(posedge clk) if (rst_n && timeout_pulse) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic t_reset;
        int v;
        rd(2'd0, v); chk("R1 lock", v, 0);
        rd(2'd1, v); chk("R1 run", v, 0);
        rd(2'd2, v); chk("R1 status", v, 0);
        rd(2'd3, v); chk("R1 timer", v, 1);
        chk("R1 pulse", int'(timeout_pulse), 0);
    endtask

    task automatic t_readonly;
        int v;
        wr(2'd1, 8'h01); wr(2'd2, 8'hFF);
        rd(2'd1, v); chk("R11 run reg", v, 0);
        rd(2'd2, v); chk("R11 status reg", v, 0);
    endtask

    task automatic t_bad_keys;
        int v;
        wr(2'd0, 8'h00); wr(2'd0, 8'h54); wr(2'd0, 8'hFF);
        rd(2'd1, v); chk("R3 bad keys", v, 0);
        step(8);
        rd(2'd3, v); chk("R3 count untouched", v, 1);
    endtask

    task automatic t_countdown;
        int v;
        wr(2'd3, 8'd3);
        rd(2'd3, v); chk("R4 load", v, 3);
        wr(2'd0, 8'h55);                 // start edge E, now n=0
        rd(2'd1, v); chk("R2 start", v, 1);
        wr(2'd3, 8'd9);                  // n=1
        rd(2'd3, v); chk("R5 refused", v, 3);
        step(2);                         // n=3
        rd(2'd3, v); chk("R6 before first minute", v, 3);
        step(1);                         // n=4
        rd(2'd3, v); chk("R6 first minute", v, 2);
        wr(2'd0, 8'h12);                 // n=5
        rd(2'd1, v); chk("R3 bad key while running", v, 1);
        step(3);                         // n=8
        rd(2'd3, v); chk("R6 second minute", v, 1);
        step(3);                         // n=11
        chk("R8 no early pulse", int'(timeout_pulse), 0);
        step(1);                         // n=12
        rd(2'd3, v); chk("R8 zero", v, 0);
        chk("R8 pulse high", int'(timeout_pulse), 1);
        rd(2'd2, v); chk("R8 status", v, 1);
        step(1);
        chk("R8 pulse one cycle", int'(timeout_pulse), 0);
        step(12);
        rd(2'd3, v); chk("R8 stays zero", v, 0);
        chk("R8 single pulse", pulses, 1);
        rd(2'd2, v); chk("R8 status sticky", v, 1);
        wr(2'd0, 8'hAA);
        rd(2'd1, v); chk("R2 stop", v, 0);
        rd(2'd2, v); chk("R10 status cleared", v, 0);
    endtask

    task automatic t_zero_start;
        int v;
        wr(2'd3, 8'd0);
        wr(2'd0, 8'h55);
        step(20);
        rd(2'd1, v); chk("R9 running", v, 1);
        rd(2'd3, v); chk("R9 count", v, 0);
        rd(2'd2, v); chk("R9 status", v, 0);
        chk("R9 no pulse", pulses, 1);
        wr(2'd0, 8'hAA);
    endtask

    task automatic t_tick_and_restart;
        int v;
        wr(2'd3, 8'd2);
        tick_in = 1'b0;
        wr(2'd0, 8'h55);
        step(10);
        rd(2'd3, v); chk("R7 stalled", v, 2);
        tick_in = 1'b1;
        step(3);
        rd(2'd3, v); chk("R7 three ticks", v, 2);
        step(1);                         // phase now 0
        rd(2'd3, v); chk("R7 four ticks", v, 1);
        wr(2'd0, 8'hAA);                 // this edge advances phase to 1
        step(10);
        rd(2'd3, v); chk("R10 frozen", v, 1);
        wr(2'd0, 8'h55);
        step(3);
        rd(2'd3, v); chk("R10 prescaler restarted", v, 1);
        step(1);
        rd(2'd3, v); chk("R10 full minute", v, 0);
        chk("R8 second pulse", int'(timeout_pulse), 1);
        wr(2'd0, 8'hAA);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_readonly();
        t_bad_keys();
        t_countdown();
        t_zero_start();
        t_tick_and_restart();
        step(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule